// File: doc/BRIEF.md
# Double-Buffered Multichannel DAC Update Controller

This block holds the digital side of a bank of analog output channels. Every channel has two registers. The host fills the preload register a byte at a time, or a word at a time. The active register drives the converter and is the block's output. The host bus is a small register window. Writes there always carry channel data. Reads of a few fixed offsets carry no data and act as commands. These commands select how preload values move into the active registers, fire a global copy, raise or drop an output-restrict flag, and control an interrupt.

There are three ways to update the outputs. In automatic mode, a channel's output follows its preload register as soon as the upper part of the value is written. In simultaneous mode, outputs change only when the host issues a global update command. In either mode an external timer pulse, when enabled, copies all channels at once on its rising edge. Each such timer update can also latch an interrupt request.

After reset the block is in simultaneous mode and the restrict flag is raised. Software can therefore load every preload register before any output moves, and then release the outputs.

Top module: `dac_update_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it: every active register reads 0, restrict_o is 1, irq_o is 0, the block is in simultaneous mode, and timer updates and interrupts are disabled.
- R2: For a channel n, the byte offset 2n is the low byte and offset 2n+1 is the high byte. A byte write places wr_data[7:0] into preload bits 7:0 at offset 2n, and places wr_data[3:0] into preload bits 11:8 at offset 2n+1. In a byte write of the high byte, wr_data[7:4] is ignored. A word write (wr_word=1) at offset 2n loads wr_data[11:0] and ignores wr_data[15:12].
- R3: In automatic mode, a high-byte write or a word write to channel n loads channel n's active register with the new 12-bit preload value one cycle later. A low-byte write alone leaves the active register unchanged.
- R4: In simultaneous mode, writes leave every active register unchanged. A read at offset 0x08 copies all preload registers into the active registers in the next cycle and leaves the block in simultaneous mode, also when it is issued from automatic mode.
- R5: A read at offset 0x0A copies all preload registers into the active registers and places the block in automatic mode.
- R6: A read at offset 0x02 places the block in automatic mode and leaves every active register unchanged.
- R7: A read at 0x0E sets restrict_o, and a read at 0x0F clears it. Neither read changes any active register.
- R8: A read at 0x05 enables timer updates, and a read at 0x06 disables them. While enabled, each rising edge of tmr_pulse copies all preload registers into the active registers within three cycles. Holding tmr_pulse high causes no further update. While disabled, pulses have no effect.
- R9: A read at 0x03 enables interrupts, and a read at 0x04 disables them. A timer update while interrupts are enabled sets irq_o. irq_o then stays set, also after interrupts are disabled, until a read at 0x0C clears it. A timer update while interrupts are disabled leaves irq_o at 0.
- R10: Commands are decoded only on reads. A write at a command offset such as 0x08 is a plain channel data write. A read at an offset with no command, such as 0x10, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_word | input | 1 | With wr_en: 16-bit write at an even offset |
| rd_en | input | 1 | Read strobe for one cycle (command decode) |
| bus_addr | input | 5 | Byte offset in the register window |
| wr_data | input | 16 | Write data; byte writes use bits 7:0 |
| tmr_pulse | input | 1 | Asynchronous timer pulse |
| active_o | output | 192 | Active registers, channel n at bits 12n+11:12n |
| restrict_o | output | 1 | Output-restrict flag |
| irq_o | output | 1 | Sticky interrupt request |

## Verification
Some behaviours are checked on every cycle. The restrict flag follows its set and clear reads. No active register moves in simultaneous mode unless a global update is issued. A high-byte write in automatic mode lands in the addressed output. The interrupt flag rises only after a timer update and falls after a clear read.

Other behaviours only the directed scenarios can show. These are the full copy of all sixteen preload values, the ignored upper data bits, writes at command offsets that do nothing more than write data, and the single update for a held timer pulse. The scenarios also show that a pulse does nothing while timer updates are disabled, and that the interrupt flag stays set after interrupts are disabled.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;
  // command offsets decoded on host reads
  localparam logic [3:0] OFS_GO_AUTO  = 4'h2;
  localparam logic [3:0] OFS_IRQ_ON   = 4'h3;
  localparam logic [3:0] OFS_IRQ_OFF  = 4'h4;
  localparam logic [3:0] OFS_TMR_ON   = 4'h5;
  localparam logic [3:0] OFS_TMR_OFF  = 4'h6;
  localparam logic [3:0] OFS_UPD_HOLD = 4'h8;
  localparam logic [3:0] OFS_UPD_AUTO = 4'hA;
  localparam logic [3:0] OFS_IRQ_CLR  = 4'hC;
  localparam logic [3:0] OFS_RSTR_SET = 4'hE;
  localparam logic [3:0] OFS_RSTR_CLR = 4'hF;

  typedef struct packed {
    logic go_auto;
    logic irq_on;
    logic irq_off;
    logic tmr_on;
    logic tmr_off;
    logic upd_hold;
    logic upd_auto;
    logic irq_clr;
    logic rstr_set;
    logic rstr_clr;
  } dac_cmd_t;
endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_ctrl_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output dac_cmd_t      cmd
);
  logic in_low;
  logic [3:0] ofs;

  assign in_low = (rd_addr >> 4) == '0;
  assign ofs    = rd_addr[3:0];

  always_comb begin
    cmd = '0;
    if (rd_en && in_low) begin
      case (ofs)
        OFS_GO_AUTO:  cmd.go_auto  = 1'b1;
        OFS_IRQ_ON:   cmd.irq_on   = 1'b1;
        OFS_IRQ_OFF:  cmd.irq_off  = 1'b1;
        OFS_TMR_ON:   cmd.tmr_on   = 1'b1;
        OFS_TMR_OFF:  cmd.tmr_off  = 1'b1;
        OFS_UPD_HOLD: cmd.upd_hold = 1'b1;
        OFS_UPD_AUTO: cmd.upd_auto = 1'b1;
        OFS_IRQ_CLR:  cmd.irq_clr  = 1'b1;
        OFS_RSTR_SET: cmd.rstr_set = 1'b1;
        OFS_RSTR_CLR: cmd.rstr_clr = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dac_pulse_sync.sv
module dac_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_async,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], pulse_async};
      last  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/dac_channel.sv
module dac_channel #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [7:0]    din_lo,
  input  logic [DW-9:0] din_hi,
  input  logic          load,
  output logic [DW-1:0] active
);
  logic [7:0]    pre_lo;
  logic [DW-9:0] pre_hi;
  logic [DW-1:0] pre_next;

  // preload keeps no reset value
  always_ff @(posedge clk) begin
    if (wr_lo) pre_lo <= din_lo;
    if (wr_hi) pre_hi <= din_hi;
  end

  assign pre_next = {wr_hi ? din_hi : pre_hi, wr_lo ? din_lo : pre_lo};

  always_ff @(posedge clk) begin
    if (rst)       active <= '0;
    else if (load) active <= pre_next;
  end
endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
  import dac_ctrl_pkg::*;
#(
  parameter int NCH = 16,
  parameter int DW  = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic                              wr_word,
  input  logic                              rd_en,
  input  logic [$clog2(NCH):0]              bus_addr,
  input  logic [15:0]                       wr_data,
  input  logic                              tmr_pulse,
  output logic [NCH*DW-1:0]                 active_o,
  output logic                              restrict_o,
  output logic                              irq_o
);
  localparam int CW = $clog2(NCH);
  localparam int AW = CW + 1;
  localparam int HW = DW - 8;

  dac_cmd_t cmd;
  logic auto_q, tmr_en_q, irq_en_q;
  logic tmr_fire, tmr_go, glob_upd;
  logic [CW-1:0] ch_sel;
  logic lo_stb, hi_stb;
  logic [HW-1:0] hi_nib;
  logic unused_upper;

  dac_cmd_decode #(.AW(AW)) u_dec (
    .rd_en(rd_en), .rd_addr(bus_addr), .cmd(cmd)
  );

  dac_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pulse_async(tmr_pulse), .rise(tmr_fire)
  );

  assign ch_sel       = bus_addr[AW-1:1];
  assign lo_stb       = wr_en & ~bus_addr[0];
  assign hi_stb       = wr_en & (bus_addr[0] | wr_word);
  assign hi_nib       = bus_addr[0] ? wr_data[HW-1:0] : wr_data[8+HW-1:8];
  assign unused_upper = ^{wr_data[15:8+HW], wr_data[7:HW]};
  assign tmr_go       = tmr_fire & tmr_en_q;
  assign glob_upd     = cmd.upd_hold | cmd.upd_auto | tmr_go;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel;
    assign sel = (ch_sel == CW'(i));
    dac_channel #(.DW(DW)) u_ch (
      .clk(clk), .rst(rst),
      .wr_lo(lo_stb & sel), .wr_hi(hi_stb & sel),
      .din_lo(wr_data[7:0]), .din_hi(hi_nib),
      .load(glob_upd | (auto_q & hi_stb & sel)),
      .active(active_o[i*DW +: DW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      auto_q     <= 1'b0;
      restrict_o <= 1'b1;
      tmr_en_q   <= 1'b0;
      irq_en_q   <= 1'b0;
      irq_o      <= 1'b0;
    end else begin
      if (cmd.go_auto | cmd.upd_auto) auto_q <= 1'b1;
      else if (cmd.upd_hold)          auto_q <= 1'b0;
      if (cmd.rstr_set)      restrict_o <= 1'b1;
      else if (cmd.rstr_clr) restrict_o <= 1'b0;
      if (cmd.tmr_on)       tmr_en_q <= 1'b1;
      else if (cmd.tmr_off) tmr_en_q <= 1'b0;
      if (cmd.irq_on)       irq_en_q <= 1'b1;
      else if (cmd.irq_off) irq_en_q <= 1'b0;
      if (tmr_go && irq_en_q) irq_o <= 1'b1;
      else if (cmd.irq_clr)   irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dac_update_ctrl_sva.sv
module dac_update_ctrl_sva #(
  parameter int NCH = 16,
  parameter int DW  = 12
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     rd_en,
  input logic                     wr_en,
  input logic [$clog2(NCH):0]     bus_addr,
  input logic [DW-9:0]            hi_nib,
  input logic [NCH*DW-1:0]        active_o,
  input logic                     restrict_o,
  input logic                     irq_o,
  input logic                     auto_q,
  input logic                     glob_upd,
  input logic                     tmr_fire
);
  localparam int CW = $clog2(NCH);
  localparam int AW = CW + 1;

  logic [CW-1:0] idx_q;
  logic [DW-9:0] nib_q;
  always_ff @(posedge clk) begin
    idx_q <= bus_addr[AW-1:1];
    nib_q <= hi_nib;
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (restrict_o && !irq_o && active_o == '0));

  assert_auto_load_R3: assert property (@(posedge clk) disable iff (rst)
    (auto_q && wr_en && bus_addr[0]) |=> active_o[idx_q*DW+8 +: DW-8] == nib_q);

  assert_sim_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!auto_q && !glob_upd) |=> $stable(active_o));

  assert_restrict_set_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && bus_addr == AW'(5'h0E)) |=> restrict_o);

  assert_restrict_clr_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && bus_addr == AW'(5'h0F)) |=> !restrict_o);

  assert_irq_rise_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(tmr_fire));

  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && bus_addr == AW'(5'h0C) && !tmr_fire) |=> !irq_o);
endmodule

bind dac_update_ctrl dac_update_ctrl_sva #(.NCH(NCH), .DW(DW)) u_sva (
  .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .bus_addr(bus_addr),
  .hi_nib(wr_data[DW-9:0]), .active_o(active_o), .restrict_o(restrict_o),
  .irq_o(irq_o), .auto_q(auto_q), .glob_upd(glob_upd), .tmr_fire(tmr_fire)
);

// File: tb/dac_update_ctrl_test.sv
module dac_update_ctrl_test;
  localparam int NCH = 16;
  localparam int DW  = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_word = 1'b0, rd_en = 1'b0, tmr_pulse = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [15:0] wr_data = '0;
  logic [NCH*DW-1:0] active_o;
  logic restrict_o, irq_o;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] exp_pre [NCH];
  logic [DW-1:0] exp_act [NCH];
  logic exp_auto, exp_rstr, exp_irq, exp_tmr, exp_irq_en;

  always #2 clk = ~clk;

  dac_update_ctrl #(.NCH(NCH), .DW(DW)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(wr_word), .rd_en(rd_en),
    .bus_addr(bus_addr), .wr_data(wr_data), .tmr_pulse(tmr_pulse),
    .active_o(active_o), .restrict_o(restrict_o), .irq_o(irq_o)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog (R1..all): actual=timeout expected=finish");
    errors++;
    summary();
    $finish;
  end

  task automatic chk(input string tag);
    bit bad = 0;
    checks++;
    for (int c = 0; c < NCH; c++)
      if (active_o[c*DW +: DW] !== exp_act[c]) begin
        if (!bad) $display("FAIL %s ch%0d actual=%h expected=%h", tag, c,
                           active_o[c*DW +: DW], exp_act[c]);
        bad = 1;
      end
    if (restrict_o !== exp_rstr) begin
      $display("FAIL %s restrict actual=%b expected=%b", tag, restrict_o, exp_rstr);
      bad = 1;
    end
    if (irq_o !== exp_irq) begin
      $display("FAIL %s irq actual=%b expected=%b", tag, irq_o, exp_irq);
      bad = 1;
    end
    if (bad) errors++;
  endtask

  task automatic wr_byte(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_word = 0; bus_addr = a; wr_data = {8'hA5, d};
    @(negedge clk);
    wr_en = 0;
    if (a[0]) exp_pre[a[4:1]][11:8] = d[3:0];
    else      exp_pre[a[4:1]][7:0]  = d;
    if (exp_auto && a[0]) exp_act[a[4:1]] = exp_pre[a[4:1]];
  endtask

  task automatic wr_wd(input int ch, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_word = 1; bus_addr = 5'(ch * 2); wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_word = 0;
    exp_pre[ch] = d[11:0];
    if (exp_auto) exp_act[ch] = exp_pre[ch];
  endtask

  task automatic copy_all();
    for (int c = 0; c < NCH; c++) exp_act[c] = exp_pre[c];
  endtask

  task automatic rd_cmd(input logic [4:0] a);
    @(negedge clk);
    rd_en = 1; bus_addr = a;
    @(negedge clk);
    rd_en = 0;
    case (a)
      5'h02: exp_auto = 1;
      5'h03: exp_irq_en = 1;
      5'h04: exp_irq_en = 0;
      5'h05: exp_tmr = 1;
      5'h06: exp_tmr = 0;
      5'h08: begin copy_all(); exp_auto = 0; end
      5'h0A: begin copy_all(); exp_auto = 1; end
      5'h0C: exp_irq = 0;
      5'h0E: exp_rstr = 1;
      5'h0F: exp_rstr = 0;
      default: ;
    endcase
  endtask

  task automatic pulse();
    @(negedge clk); tmr_pulse = 1;
    repeat (4) @(negedge clk);
    tmr_pulse = 0;
    repeat (3) @(negedge clk);
    if (exp_tmr) begin
      copy_all();
      if (exp_irq_en) exp_irq = 1;
    end
  endtask

  task automatic t_reset();
    for (int c = 0; c < NCH; c++) exp_act[c] = '0;
    exp_auto = 0; exp_rstr = 1; exp_irq = 0; exp_tmr = 0; exp_irq_en = 0;
    chk("R1 reset state");
  endtask

  task automatic t_sim_load();
    wr_byte(5'h06, 8'h3C);
    wr_byte(5'h07, 8'hF5);
    chk("R4 byte writes held in simultaneous mode");
    for (int c = 0; c < NCH; c++) wr_wd(c, 16'hF000 | 16'(c * 16'h0111 + 3));
    wr_byte(5'h07, 8'hF5);
    chk("R4 word writes held in simultaneous mode");
    rd_cmd(5'h08);
    chk("R2 R4 global update copies all channels");
    wr_byte(5'h01, 8'h09);
    chk("R4 still simultaneous after update");
  endtask

  task automatic t_no_write_cmd();
    wr_byte(5'h08, 8'h77);
    chk("R10 write at 0x08 is channel data only");
    rd_cmd(5'h10);
    chk("R10 read of unused offset ignored");
  endtask

  task automatic t_auto();
    rd_cmd(5'h0A);
    chk("R5 update and enter automatic");
    wr_byte(5'h02, 8'h5A);
    chk("R3 low byte alone does not load");
    wr_byte(5'h03, 8'hE7);
    chk("R3 high byte loads channel 1");
    wr_wd(2, 16'h9ABC);
    chk("R3 R2 word write loads channel 2");
  endtask

  task automatic t_go_auto();
    rd_cmd(5'h08);
    wr_wd(5, 16'h0321);
    chk("R4 update command from automatic returns to simultaneous");
    rd_cmd(5'h02);
    chk("R6 enter automatic without update");
    wr_byte(5'h0B, 8'h0D);
    chk("R6 R3 automatic after 0x02 loads on high byte");
  endtask

  task automatic t_restrict();
    rd_cmd(5'h0F);
    chk("R7 restrict cleared");
    rd_cmd(5'h0E);
    chk("R7 restrict set, outputs kept");
    rd_cmd(5'h0F);
    chk("R7 restrict cleared again");
  endtask

  task automatic t_timer();
    rd_cmd(5'h08);
    wr_wd(6, 16'h0AAA);
    pulse();
    chk("R8 pulse ignored while disabled");
    rd_cmd(5'h05);
    pulse();
    chk("R8 R9 timer update, irq disabled stays low");
    @(negedge clk); tmr_pulse = 1;
    repeat (5) @(negedge clk);
    copy_all();
    wr_wd(6, 16'h0555);
    repeat (5) @(negedge clk);
    chk("R8 held pulse updates only once");
    tmr_pulse = 0;
    repeat (3) @(negedge clk);
    rd_cmd(5'h03);
    wr_wd(7, 16'h0123);
    pulse();
    chk("R9 timer update with irq enabled sets irq");
    rd_cmd(5'h06);
    rd_cmd(5'h04);
    wr_wd(8, 16'h0FED);
    pulse();
    chk("R9 R8 irq sticky, disabled timer ignored");
    rd_cmd(5'h0C);
    chk("R9 irq cleared by 0x0C");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    @(negedge clk);
    t_reset();
    t_sim_load();
    t_no_write_cmd();
    t_auto();
    t_go_auto();
    t_restrict();
    t_timer();
    summary();
    $finish;
  end
endmodule